// File: doc/BRIEF.md
# Page Write Buffer and Address Pointer

This block sits between a serial-bus slave engine and a synchronous byte-wide storage array. It keeps the internal address pointer, gathers incoming write bytes into a page buffer, and on a STOP commits every byte it received to the array in one self-timed write cycle. For reads it fetches the byte at the pointer and then advances the pointer across the whole array.

The slave engine loads a word address, streams write bytes, and signals STOP. On writes only the in-page offset of the pointer advances, so a stream longer than a page folds back and overwrites earlier bytes of that same page. A per-byte valid mask makes sure that only received bytes are programmed. A busy flag covers the whole write cycle, and the block ignores the engine while the flag is high. A write-protect input discards the buffered page instead of committing it. Array size, page size and write-cycle length in clock cycles are all parameters.

Top module: `page_write_pointer`

## Requirements
- R1: After reset, `busy`, `rd_vld` and `mem_wr_en` are 0, and the pointer is 0, so the first read returns array location 0.
- R2: Each accepted write byte is stored at the pointer's page offset (the low log2(PAGE_BYTES) bits). Only that offset then increments, modulo PAGE_BYTES; the upper pointer bits stay unchanged.
- R3: When more than PAGE_BYTES bytes arrive before STOP, the offset wraps and each later byte replaces the earlier byte at the same offset. Only the last value at each offset reaches the array.
- R4: The array is never written before `stop_evt`. After a STOP with at least one buffered byte, exactly one array write is made per distinct buffered offset, and every one falls inside the busy window.
- R5: `busy` rises on the cycle after the accepted STOP and stays high for exactly WRITE_CYCLES clock cycles. While it is high, `addr_load`, `wr_vld`, `rd_req` and `stop_evt` have no effect.
- R6: Bytes of the page that were not received keep their previous array contents.
- R7: A `rd_req` while idle presents the pointer on `mem_addr` with `mem_rd_en` in the same cycle. `rd_vld` is high on the next cycle, with the array byte on `rd_data`. The full pointer then increments by one.
- R8: A read at location ARRAY_BYTES-1 moves the pointer to location 0.
- R9: After a page write, the pointer holds the address that follows the last received byte, with the in-page wrap applied, so a current-address read returns that location.
- R10: With `wp_en` high at STOP, the buffered bytes are discarded: there is no array write and `busy` stays low.
- R11: A STOP with no buffered byte starts no write cycle. A new `addr_load` discards any bytes that have not been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_en | input | 1 | Write protect, sampled at STOP |
| addr_load | input | 1 | Load the word address into the pointer |
| addr_load_val | input | AW | Word address to load |
| wr_vld | input | 1 | One write byte is present |
| wr_data | input | 8 | Write byte |
| stop_evt | input | 1 | STOP seen after a write |
| rd_req | input | 1 | Fetch the byte at the pointer |
| rd_vld | output | 1 | `rd_data` is valid |
| rd_data | output | 8 | Byte read from the array |
| busy | output | 1 | Write cycle in progress |
| mem_wr_en | output | 1 | Array write strobe |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | AW | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_rd_en` |

## Verification
The bench builds the block at the smallest density: 128 bytes with 8-byte pages and a 12-cycle write cycle. With those values the array-end wrap at location 127 takes only a few reads, and a page overrun needs only nine bytes, so a 16-byte stream folds the offset twice. The short write cycle lets the bench count the busy window exactly and still drive stray loads, bytes and reads into it.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pwp_addr_ptr.sv
module pwp_addr_ptr #(
   parameter int unsigned AW = 8,
   parameter int unsigned OW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          wr_step,
   input  logic          rd_step,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] wr_next;

   if (OW > AW) begin : g_bad_ow
      $error("pwp_addr_ptr: offset wider than pointer");
   end

   if (OW == AW) begin : g_flat
      // page spans the whole array: offset step is the full step
      always_comb wr_next = ptr + 1'b1;
   end else begin : g_split
      always_comb wr_next = {ptr[AW-1:OW], ptr[OW-1:0] + 1'b1};

      AST_PAGE_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_step && !load) |=> $stable(ptr[AW-1:OW])); // R2
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_addr;
      end else if (wr_step) begin
         ptr <= wr_next;
      end else if (rd_step) begin
         ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/pwp_page_buf.sv
module pwp_page_buf #(
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned OW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [OW-1:0] wr_off,
   input  logic [7:0]    wr_data,
   input  logic [OW-1:0] sel_off,
   output logic [7:0]    sel_data,
   output logic          sel_valid,
   output logic          any_valid
);
   logic [7:0]            data_arr [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_vec;

   if ((1 << OW) != PAGE_BYTES) begin : g_bad_page
      $error("pwp_page_buf: PAGE_BYTES must equal 2**OW");
   end

   for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
      logic [7:0] d_q;
      logic       v_q;
      logic       hit;

      assign hit = wr_en && (wr_off == OW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            if (clr) begin
               v_q <= 1'b0;
            end else if (hit) begin
               v_q <= 1'b1;
            end
            if (hit && !clr) begin
               d_q <= wr_data;
            end
         end
      end

      assign data_arr[i] = d_q;
      assign vld_vec[i]  = v_q;
   end

   assign sel_data  = data_arr[sel_off];
   assign sel_valid = vld_vec[sel_off];
   assign any_valid = |vld_vec;

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any_valid); // R11
endmodule

// File: rtl/pwp_commit_seq.sv
module pwp_commit_seq
   import pwp_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 1000,
   parameter int unsigned PAGE_BYTES   = 16,
   parameter int unsigned OW           = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stop_evt,
   input  logic          wp,
   input  logic          any_valid,
   output logic          busy,
   output logic          issue,
   output logic [OW-1:0] issue_off,
   output logic          buf_clr
);
   localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);

   seq_state_t    state_q;
   logic [CW-1:0] cnt_q;
   logic          last;
   logic          start;

   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_wc
      $error("pwp_commit_seq: WRITE_CYCLES must cover one cycle per page byte");
   end

   assign busy      = (state_q == SEQ_BUSY);
   assign last      = busy && (cnt_q == CW'(WRITE_CYCLES - 1));
   assign start     = !busy && stop_evt && any_valid && !wp;
   assign issue     = busy && (cnt_q < CW'(PAGE_BYTES));
   assign issue_off = cnt_q[OW-1:0];
   // protected or empty STOP drops the page; a finished cycle clears it
   assign buf_clr   = (!busy && stop_evt && !start) || last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               cnt_q <= '0;
               if (start) begin
                  state_q <= SEQ_BUSY;
               end
            end
            SEQ_BUSY: begin
               cnt_q <= cnt_q + 1'b1;
               if (last) begin
                  state_q <= SEQ_IDLE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy); // R5
   AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt)); // R4
endmodule

// File: rtl/page_write_pointer.sv
module page_write_pointer #(
   parameter int unsigned ARRAY_BYTES  = 256,
   parameter int unsigned PAGE_BYTES   = 16,
   parameter int unsigned WRITE_CYCLES = 1000,
   localparam int unsigned AW = $clog2(ARRAY_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wp_en,
   input  logic          addr_load,
   input  logic [AW-1:0] addr_load_val,
   input  logic          wr_vld,
   input  logic [7:0]    wr_data,
   input  logic          stop_evt,
   input  logic          rd_req,
   output logic          rd_vld,
   output logic [7:0]    rd_data,
   output logic          busy,
   output logic          mem_wr_en,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata
);
   localparam int unsigned OW = $clog2(PAGE_BYTES);

   if ((1 << AW) != ARRAY_BYTES) begin : g_bad_array
      $error("page_write_pointer: ARRAY_BYTES must be a power of two");
   end
   if ((1 << OW) != PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_page
      $error("page_write_pointer: PAGE_BYTES must be a power of two, at least 2");
   end
   if (PAGE_BYTES > ARRAY_BYTES) begin : g_bad_ratio
      $error("page_write_pointer: page larger than array");
   end

   logic          idle;
   logic          load_g;
   logic          wr_g;
   logic          rd_g;
   logic          stop_g;
   logic [AW-1:0] ptr;
   logic          any_valid;
   logic          sel_valid;
   logic [7:0]    sel_data;
   logic          issue;
   logic [OW-1:0] issue_off;
   logic          seq_clr;
   logic [AW-1:0] commit_addr;
   logic          rd_vld_q;

   assign idle   = !busy;
   assign load_g = addr_load && idle;
   assign wr_g   = wr_vld && idle && !addr_load;
   assign rd_g   = rd_req && idle && !addr_load && !wr_vld;
   assign stop_g = stop_evt && idle;

   pwp_addr_ptr #(
      .AW (AW),
      .OW (OW)
   ) ptr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_g),
      .load_addr (addr_load_val),
      .wr_step   (wr_g),
      .rd_step   (rd_g),
      .ptr       (ptr)
   );

   pwp_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .OW         (OW)
   ) buf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (seq_clr || load_g),
      .wr_en     (wr_g),
      .wr_off    (ptr[OW-1:0]),
      .wr_data   (wr_data),
      .sel_off   (issue_off),
      .sel_data  (sel_data),
      .sel_valid (sel_valid),
      .any_valid (any_valid)
   );

   pwp_commit_seq #(
      .WRITE_CYCLES (WRITE_CYCLES),
      .PAGE_BYTES   (PAGE_BYTES),
      .OW           (OW)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_evt  (stop_g),
      .wp        (wp_en),
      .any_valid (any_valid),
      .busy      (busy),
      .issue     (issue),
      .issue_off (issue_off),
      .buf_clr   (seq_clr)
   );

   if (OW == AW) begin : g_flat_addr
      assign commit_addr = issue_off;
   end else begin : g_paged_addr
      // pointer upper bits are frozen while busy, so they name the page
      assign commit_addr = {ptr[AW-1:OW], issue_off};
   end

   assign mem_wr_en = issue && sel_valid;
   assign mem_wdata = sel_data;
   assign mem_rd_en = rd_g;
   assign mem_addr  = busy ? commit_addr : ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld_q <= 1'b0;
      end else begin
         rd_vld_q <= rd_g;
      end
   end

   assign rd_vld  = rd_vld_q;
   assign rd_data = mem_rdata;

   AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> busy); // R4
   AST_NO_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !busy); // R5
   AST_RD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> rd_vld); // R7
   AST_WP_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp_en && !busy) |=> !busy); // R10
endmodule

// File: tb/page_write_pointer_tb.sv
module page_write_pointer_tb_top;
   localparam int ARRAY = 128;
   localparam int PAGE  = 8;
   localparam int WC    = 12;
   localparam int AW    = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_en = 1'b0;
   logic          addr_load = 1'b0;
   logic [AW-1:0] addr_load_val = '0;
   logic          wr_vld = 1'b0;
   logic [7:0]    wr_data = '0;
   logic          stop_evt = 1'b0;
   logic          rd_req = 1'b0;
   logic          rd_vld;
   logic [7:0]    rd_data;
   logic          busy;
   logic          mem_wr_en;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int wr_cnt = 0;
   logic [7:0] arr [ARRAY];
   logic [7:0] exp_mem [ARRAY];
   logic [AW-1:0] exp_ptr;

   // start, count, seed
   localparam logic [19:0] VECS [6] = '{
      {7'h05, 5'd4,  8'h10},
      {7'h3E, 5'd3,  8'h20},
      {7'h40, 5'd8,  8'h30},
      {7'h7A, 5'd11, 8'h40},
      {7'h21, 5'd1,  8'h50},
      {7'h57, 5'd16, 8'h60}
   };

   always #2 clk = ~clk;

   page_write_pointer #(
      .ARRAY_BYTES  (ARRAY),
      .PAGE_BYTES   (PAGE),
      .WRITE_CYCLES (WC)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wp_en         (wp_en),
      .addr_load     (addr_load),
      .addr_load_val (addr_load_val),
      .wr_vld        (wr_vld),
      .wr_data       (wr_data),
      .stop_evt      (stop_evt),
      .rd_req        (rd_req),
      .rd_vld        (rd_vld),
      .rd_data       (rd_data),
      .busy          (busy),
      .mem_wr_en     (mem_wr_en),
      .mem_rd_en     (mem_rd_en),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata)
   );

   // storage array model with one-cycle read latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ARRAY; i++) arr[i] <= 8'(i * 3 + 1);
      end else begin
         if (mem_wr_en) begin
            arr[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end
         if (mem_rd_en) mem_rdata <= arr[mem_addr];
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [AW-1:0] a);
      addr_load = 1'b1; addr_load_val = a;
      @(negedge clk);
      addr_load = 1'b0;
   endtask

   task automatic do_wbyte(input logic [7:0] d);
      wr_vld = 1'b1; wr_data = d;
      @(negedge clk);
      wr_vld = 1'b0;
   endtask

   task automatic do_stop();
      stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
   endtask

   task automatic do_read(output logic v, output logic [7:0] d);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      v = rd_vld; d = rd_data;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic       v;
      logic [7:0] d;
      int         n;
      int         w0;

      for (int i = 0; i < ARRAY; i++) exp_mem[i] = 8'(i * 3 + 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 rd_vld", rd_vld, 0);
      chk("R1 mem_wr_en", mem_wr_en, 0);
      do_read(v, d);
      chk("R1 first read vld", v, 1);
      chk("R1 first read location 0", d, exp_mem[0]);
      @(negedge clk);
      chk("R7 rd_vld single cycle", rd_vld, 0);
      do_read(v, d);
      chk("R7 pointer advanced", d, exp_mem[1]);

      // vector table: page writes followed by readback
      foreach (VECS[k]) begin
         logic [AW-1:0] st;
         int            cnt;
         logic [7:0]    seed;
         logic [AW-1:0] base;
         int            off;
         bit            hit [PAGE];
         st = VECS[k][19:13]; cnt = int'(VECS[k][12:8]); seed = VECS[k][7:0];
         base = st & ~AW'(PAGE - 1);
         off  = int'(st) % PAGE;
         for (int j = 0; j < PAGE; j++) hit[j] = 1'b0;
         w0 = wr_cnt;
         do_load(st);
         for (int i = 0; i < cnt; i++) begin
            int o;
            o = (off + i) % PAGE;
            do_wbyte(8'(seed + i * 7));
            exp_mem[base | AW'(o)] = 8'(seed + i * 7);
            hit[o] = 1'b1;
         end
         chk("R4 no write before stop", wr_cnt - w0, 0);
         do_stop();
         wait_idle(n);
         chk("R5 busy length", n, WC);
         chk("R4 writes per distinct offset", wr_cnt - w0, (cnt > PAGE) ? PAGE : cnt);
         exp_ptr = base | AW'((off + cnt) % PAGE);
         do_read(v, d);
         chk("R9 current address after write", d, exp_mem[exp_ptr]);
         do_load(base);
         for (int j = 0; j < PAGE; j++) begin
            do_read(v, d);
            if (cnt > PAGE)   chk("R3 overrun keeps last", d, exp_mem[base | AW'(j)]);
            else if (hit[j])  chk("R2 stored at offset", d, exp_mem[base | AW'(j)]);
            else              chk("R6 untouched byte kept", d, exp_mem[base | AW'(j)]);
         end
      end

      // R8 array-end wrap on read
      do_load(7'h7F);
      do_read(v, d);
      chk("R8 last location", d, exp_mem[7'h7F]);
      do_read(v, d);
      chk("R8 wrap to location 0", d, exp_mem[0]);

      // R10 write protect discards the page
      w0 = wr_cnt;
      wp_en = 1'b1;
      do_load(7'h10);
      do_wbyte(8'hAA);
      do_wbyte(8'hBB);
      do_stop();
      chk("R10 busy stays low", busy, 0);
      wp_en = 1'b0;
      do_stop();
      chk("R10 buffer discarded", busy, 0);
      chk("R10 no array write", wr_cnt - w0, 0);
      do_load(7'h10);
      do_read(v, d);
      chk("R10 location 0x10 unchanged", d, exp_mem[7'h10]);
      do_read(v, d);
      chk("R10 location 0x11 unchanged", d, exp_mem[7'h11]);

      // R11 empty stop and reload discard
      do_load(7'h22);
      do_stop();
      chk("R11 empty stop no busy", busy, 0);
      do_load(7'h30);
      do_wbyte(8'h5C);
      do_load(7'h30);
      do_stop();
      chk("R11 reload discards byte", busy, 0);
      do_read(v, d);
      chk("R11 location 0x30 unchanged", d, exp_mem[7'h30]);

      // R5 inputs ignored during the write cycle
      w0 = wr_cnt;
      do_load(7'h48);
      do_wbyte(8'h77);
      exp_mem[7'h48] = 8'h77;
      do_stop();
      do_load(7'h00);
      do_wbyte(8'h99);
      do_read(v, d);
      chk("R5 read ignored while busy", v, 0);
      do_stop();
      wait_idle(n);
      chk("R5 busy length with stray inputs", n + 4, WC);
      chk("R5 single array write", wr_cnt - w0, 1);
      do_stop();
      chk("R5 stray byte not buffered", busy, 0);
      do_read(v, d);
      chk("R5 load ignored, pointer kept", d, exp_mem[7'h49]);
      do_load(7'h48);
      do_read(v, d);
      chk("R5 committed byte", d, 8'h77);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule